// File: doc/BRIEF.md
# Converter Result Holding and Trigger Select Front End

This block sits between a microcontroller register bus and a 10-bit successive-approximation converter. It keeps the most recent conversion value and shows it to software as a low and a high data byte. The value can be packed toward bit 0 or toward the top of the high byte. A lock stops a half-read result from being torn: once software reads the low byte, newly finished conversions are discarded until the high byte is read.

The block also decides when a new conversion starts. Software can request one directly. In automatic mode, a three-bit source select picks one of four internal event flags, and the rising edge of the multiplexed flag starts a conversion. Select value 0 makes the converter restart right after each finished conversion. Start requests that arrive while a conversion is still running are dropped.

Two small state machines carry the behaviour. The read lock machine has states RD_OPEN and RD_LOCKED. A low-byte read moves it from RD_OPEN to RD_LOCKED, and a high-byte read moves it from RD_LOCKED back to RD_OPEN. The converter-activity machine has states CV_IDLE and CV_BUSY. An issued start moves it from CV_IDLE to CV_BUSY. A done strobe with no new start moves it from CV_BUSY back to CV_IDLE. A done strobe that comes together with a new start keeps it in CV_BUSY.

Top module: `adc_result_trigger`

## Requirements
- R1: After reset, all four registers read 0x00 and `conv_start` is low.
- R2: With the left-adjust bit clear, address 0 returns result bits 7:0, and address 1 returns result bits 9:8 in its bits 1:0 with zeros above them.
- R3: With the left-adjust bit set, address 1 returns result bits 9:2, and address 0 returns result bits 1:0 in its bits 7:6 with zeros below them.
- R4: A write to the left-adjust bit changes the data byte readout on the next read without a new conversion, even while a conversion is running.
- R5: A read of address 0 locks the data bytes. Done strobes that arrive while the bytes are locked are discarded. A read of address 1 unlocks them.
- R6: Reading address 1 alone never locks. A later done strobe updates both bytes.
- R7: Address 2 is the configuration register. Bits 2:0 are the source select, bit 4 is left-adjust, and bits 3 and 5 are spare bits that read back what was written. Bits 7:6 read 0.
- R8: With enable (address 3 bit 0) and auto mode (address 3 bit 1) both set, select values 1, 2, 3 and 4 take `trig_flags` bits 0, 1, 2 and 3. A rising edge on the selected flag starts a conversion on the next cycle. With auto mode clear, no flag starts a conversion.
- R9: Changing the select from a low source to a high source is itself a rising edge and starts a conversion.
- R10: Switching the select to 0 never starts a conversion. With select 0 and auto mode on, `conv_start` pulses on the cycle after every `conv_done` strobe.
- R11: `conv_start` is a single-cycle pulse. A start request made while a conversion is running (after a start and before its done) is dropped. Select values 5 to 7 have no source and never trigger.
- R12: Writing address 3 with bits 0 and 2 both set issues a start on the next cycle. Bit 2 always reads 0, and address 3 reads {5'b0, 0, auto, enable}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; side effects take place at the clock edge |
| bus_addr | input | 2 | Register address: 0 low data, 1 high data, 2 configuration, 3 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| conv_done | input | 1 | One-cycle strobe from the converter when a result is ready |
| conv_result | input | 10 | Converter result, valid with `conv_done` |
| trig_flags | input | 4 | Event flags: comparator, external request, timer match, timer overflow |
| conv_start | output | 1 | One-cycle start request to the converter |

## Verification
The bench goes after the lock window. It sends a done strobe between a low-byte read and a high-byte read, and expects the old value to survive. A design that locks on the wrong byte, or never unlocks, would tear the value or freeze it. The bench also checks that a high-byte-only read leaves later updates flowing, and that the left-adjust bit changes the layout with no new conversion.

On the trigger side, the bench moves the select from a low source to a high source and expects a start. It moves the select to 0 while a flag is high and expects none. A design that detects edges before the multiplexer, or that trips on select 0, would fail one of these two checks. Starts sent while the converter is busy must vanish, and select codes 5 to 7 must stay silent even with every flag high.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;
    typedef enum logic {RD_OPEN, RD_LOCKED} lock_state_t;
    typedef enum logic {CV_IDLE, CV_BUSY} conv_state_t;

    localparam logic [1:0] ADDR_LO  = 2'd0;
    localparam logic [1:0] ADDR_HI  = 2'd1;
    localparam logic [1:0] ADDR_CFG = 2'd2;
    localparam logic [1:0] ADDR_CTL = 2'd3;
endpackage

// File: rtl/adc_result_hold.sv
module adc_result_hold
    import adc_fe_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_lo,
    input  logic              rd_hi,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    input  logic              left_adj,
    output logic [BYTE_W-1:0] data_lo,
    output logic [BYTE_W-1:0] data_hi
);
    localparam int HI_BITS = RES_W - BYTE_W;

    lock_state_t      state_q, state_d;
    logic [RES_W-1:0] raw_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_OPEN:   if (rd_lo) state_d = RD_LOCKED;
            RD_LOCKED: if (rd_hi) state_d = RD_OPEN;
            default:   state_d = RD_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_OPEN;
            raw_q   <= '0;
        end else begin
            state_q <= state_d;
            if (conv_done && state_d == RD_OPEN)
                raw_q <= conv_result;
        end
    end

    always_comb begin
        if (left_adj) begin
            data_hi = raw_q[RES_W-1 -: BYTE_W];
            data_lo = BYTE_W'(raw_q[HI_BITS-1:0]) << (BYTE_W - HI_BITS);
        end else begin
            data_hi = BYTE_W'(raw_q[RES_W-1:BYTE_W]);
            data_lo = raw_q[BYTE_W-1:0];
        end
    end

    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == RD_LOCKED && !rd_hi) || rd_lo) |=> $stable(raw_q));

    // R6
    open_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_OPEN && !rd_lo && conv_done) |=> (raw_q == $past(conv_result)));
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
    parameter int SEL_W = 3,
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic [N_SRC-1:0] flags,
    output logic             edge_o
);
    logic mux_val, prev_q;

    // Select 0 and every code above N_SRC feed a constant low.
    always_comb begin
        mux_val = 1'b0;
        for (int i = 0; i < N_SRC; i++)
            if (sel == SEL_W'(i + 1)) mux_val = flags[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= mux_val;
    end

    assign edge_o = mux_val & ~prev_q;
endmodule

// File: rtl/adc_conv_ctl.sv
module adc_conv_ctl
    import adc_fe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic conv_done,
    output logic conv_start
);
    conv_state_t state_q, state_d;
    logic        issue;

    assign issue = req && (state_q == CV_IDLE || conv_done);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CV_IDLE: if (issue) state_d = CV_BUSY;
            CV_BUSY: if (issue) state_d = CV_BUSY;
                     else if (conv_done) state_d = CV_IDLE;
            default: state_d = CV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CV_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) conv_start <= 1'b0;
        else        conv_start <= issue;
    end

    // R11
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CV_BUSY && !conv_done) |=> !conv_start);

    // R11
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !conv_done) |=> !conv_start);
endmodule

// File: rtl/adc_result_trigger.sv
module adc_result_trigger
    import adc_fe_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    input  logic [N_SRC-1:0] trig_flags,
    output logic             conv_start
);
    localparam int SEL_W = 3;

    logic [5:0]       cfg_q;
    logic             en_q, auto_q;
    logic [SEL_W-1:0] sel;
    logic             left_adj, trig_edge, sw_go, hw_go;
    logic [7:0]       data_lo, data_hi;
    logic             unused_wbits;

    assign unused_wbits = ^{bus_wdata[7:6]};
    assign sel      = cfg_q[SEL_W-1:0];
    assign left_adj = cfg_q[4];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            en_q   <= 1'b0;
            auto_q <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_CFG) cfg_q <= bus_wdata[5:0];
            if (bus_addr == ADDR_CTL) begin
                en_q   <= bus_wdata[0];
                auto_q <= bus_wdata[1];
            end
        end
    end

    assign sw_go = bus_wr && bus_addr == ADDR_CTL && bus_wdata[0] && bus_wdata[2];
    assign hw_go = en_q && auto_q && ((sel == '0) ? conv_done : trig_edge);

    adc_result_hold #(.RES_W(RES_W), .BYTE_W(8)) u_hold (
        .clk(clk), .rst_n(rst_n),
        .rd_lo(bus_rd && bus_addr == ADDR_LO),
        .rd_hi(bus_rd && bus_addr == ADDR_HI),
        .conv_done(conv_done), .conv_result(conv_result),
        .left_adj(left_adj), .data_lo(data_lo), .data_hi(data_hi)
    );

    adc_trig_sel #(.SEL_W(SEL_W), .N_SRC(N_SRC)) u_trig (
        .clk(clk), .rst_n(rst_n), .sel(sel), .flags(trig_flags), .edge_o(trig_edge)
    );

    adc_conv_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .req(sw_go || hw_go),
        .conv_done(conv_done), .conv_start(conv_start)
    );

    always_comb begin
        unique case (bus_addr)
            ADDR_LO:  bus_rdata = data_lo;
            ADDR_HI:  bus_rdata = data_hi;
            ADDR_CFG: bus_rdata = {2'b00, cfg_q};
            default:  bus_rdata = {6'b0, auto_q, en_q};
        endcase
    end

    // R10
    free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && auto_q && sel == '0 && conv_done) |=> conv_start);

    // R10
    free_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0 && !conv_done && !sw_go) |=> !conv_start);

    // R8
    auto_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_q && !sw_go) |=> !conv_start);
endmodule

// File: tb/tb_adc_result_trigger.sv
`timescale 1ns/1ps
module tb_adc_result_trigger;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       conv_done = 1'b0;
    logic [9:0] conv_result = '0;
    logic [3:0] trig_flags = '0;
    logic       conv_start;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    adc_result_trigger dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .conv_done(conv_done), .conv_result(conv_result),
        .trig_flags(trig_flags), .conv_start(conv_start)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(posedge clk);
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic conv(input logic [9:0] val, output logic st);
        @(negedge clk); conv_done = 1'b1; conv_result = val;
        @(posedge clk);
        @(negedge clk); conv_done = 1'b0; st = conv_start;
    endtask

    task automatic quiet(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); check(req, {7'b0, conv_start}, 8'h00);
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 start", {7'b0, conv_start}, 8'h00);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v); check("R1 reg", v, 8'h00);
        end
    endtask

    task automatic t_cfg();
        logic [7:0] v;
        wr(2, 8'hFF); rd(2, v); check("R7 all ones", v, 8'h3F);
        wr(2, 8'h28); rd(2, v); check("R7 spare bits", v, 8'h28);
        wr(2, 8'h00);
    endtask

    task automatic t_layout();
        logic [7:0] v; logic st;
        conv(10'h2A5, st);
        rd(0, v); check("R2 low", v, 8'hA5);
        rd(1, v); check("R2 high", v, 8'h02);
        wr(3, 8'h05);
        wr(2, 8'h10);
        rd(1, v); check("R3 high", v, 8'hA9);
        rd(0, v); check("R3 low", v, 8'h40);
        wr(2, 8'h00);
        rd(0, v); check("R4 back to right", v, 8'hA5);
        rd(1, v); check("R4 back high", v, 8'h02);
        conv(10'h000, st); check("R4 no restart", {7'b0, st}, 8'h00);
        wr(3, 8'h00);
    endtask

    task automatic t_lock();
        logic [7:0] v; logic st;
        conv(10'h155, st);
        rd(0, v); check("R5 low", v, 8'h55);
        conv(10'h3FF, st);
        rd(0, v); check("R5 locked low", v, 8'h55);
        rd(1, v); check("R5 locked high", v, 8'h01);
        rd(0, v); check("R5 dropped", v, 8'h55);
        rd(1, v);
        conv(10'h0F0, st);
        rd(0, v); check("R5 after unlock", v, 8'hF0);
        rd(1, v); check("R5 after unlock high", v, 8'h00);
    endtask

    task automatic t_hi_only();
        logic [7:0] v; logic st;
        conv(10'h300, st);
        rd(1, v); check("R6 high", v, 8'h03);
        conv(10'h1C3, st);
        rd(1, v); check("R6 updated high", v, 8'h01);
        rd(0, v); check("R6 updated low", v, 8'hC3);
        rd(1, v);
    endtask

    task automatic t_manual();
        logic [7:0] v; logic st;
        wr(3, 8'h05); check("R12 start", {7'b0, conv_start}, 8'h01);
        @(negedge clk); check("R11 one cycle", {7'b0, conv_start}, 8'h00);
        rd(3, v); check("R12 readback", v, 8'h01);
        wr(3, 8'h05); check("R11 busy drop", {7'b0, conv_start}, 8'h00);
        conv(10'h000, st); check("R11 done no start", {7'b0, st}, 8'h00);
        wr(3, 8'h04); check("R12 needs enable", {7'b0, conv_start}, 8'h00);
    endtask

    task automatic t_edges();
        logic st;
        wr(3, 8'h03);
        for (int s = 1; s <= 4; s++) begin
            wr(2, 8'(s));
            @(negedge clk); trig_flags[s-1] = 1'b1;
            @(negedge clk); check("R8 source edge", {7'b0, conv_start}, 8'h01);
            conv(10'h000, st); check("R8 level no retrigger", {7'b0, st}, 8'h00);
            trig_flags = '0;
        end
        wr(3, 8'h01); wr(2, 8'h01);
        @(negedge clk); trig_flags[0] = 1'b1;
        quiet("R8 auto off", 3);
        trig_flags = '0;
    endtask

    task automatic t_switch();
        logic st;
        wr(3, 8'h03);
        wr(2, 8'h01);
        @(negedge clk); trig_flags = 4'b0100;
        quiet("R9 low source", 2);
        wr(2, 8'h03);
        check("R9 same cycle", {7'b0, conv_start}, 8'h00);
        @(negedge clk); check("R9 switch edge", {7'b0, conv_start}, 8'h01);
        conv(10'h000, st);
        wr(2, 8'h00);
        quiet("R10 switch to free", 3);
        conv(10'h111, st); check("R10 free run", {7'b0, st}, 8'h01);
        @(negedge clk); check("R11 free pulse", {7'b0, conv_start}, 8'h00);
        conv(10'h112, st); check("R10 free run again", {7'b0, st}, 8'h01);
        wr(3, 8'h01);
        conv(10'h000, st); check("R10 auto off", {7'b0, st}, 8'h00);
        trig_flags = '0;
    endtask

    task automatic t_nosrc();
        logic st;
        wr(3, 8'h03);
        @(negedge clk); trig_flags = 4'hF;
        for (int s = 5; s <= 7; s++) begin
            wr(2, 8'(s));
            quiet("R11 empty select", 2);
        end
        trig_flags = '0;
        wr(2, 8'h01);
        wr(3, 8'h07); check("R12 start in auto", {7'b0, conv_start}, 8'h01);
        @(negedge clk); trig_flags[0] = 1'b1;
        quiet("R11 edge while busy", 2);
        conv(10'h000, st);
        trig_flags = '0;
        wr(3, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_cfg();
        t_layout();
        t_lock();
        t_hi_only();
        t_manual();
        t_edges();
        t_switch();
        t_nosrc();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule